// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side master for a DAC that takes 24-bit frames over a three-wire serial link. A request carries a 16-bit output code and a 2-bit power mode. When the block accepts a request, it raises the frame-select line (`sync`) for a fixed minimum time to arm the receiver. It then drops `sync` and shifts the frame out most significant bit first. It produces the serial clock by dividing the system clock. The receiver samples `din` on each falling edge of `sclk`.

The frame takes effect on the 24th falling edge of `sclk`. In the cycle where that edge appears on the pin, the block pulses `done` and raises `req_ready`. The last low half-period of `sclk` is still running at that point. If a new request arrives during it, the block cuts that half-period short and starts the next frame straight away. Between frames `sync` rests low to save power. `sclk` rests high. The SYNC-high time comes from parameters given in picoseconds, rounded up to whole system clocks. The SCLK half-period is clamped so the serial clock never runs faster than its limit.

Top module: `dac_frame_writer`

## Requirements
- R1: Each frame is 24 bits, sent most significant bit first. Bits 23..18 are zero, bits 17..16 carry `req_mode[1:0]`, and bits 15..0 carry `req_code[15:0]`.
- R2: `din` changes only at the cycle where `sync` falls or where `sclk` rises. It never changes in the cycle where `sclk` falls, so each bit is held for one full half-period before the edge that samples it.
- R3: After a request is accepted, `sync` goes high in the next cycle and stays high for exactly ceil(SYNC_MIN_PS / CLK_PERIOD_PS) cycles. With the defaults this is 9 cycles. During this time `sclk` is high and `din` is 0.
- R4: Out of reset, `sync`=0, `sclk`=1, `din`=0, `req_ready`=1 and `done`=0. `sync` stays low while idle, and it stays low from its falling edge until the 24th falling edge of `sclk`.
- R5: Within a frame, each high and low phase of `sclk` lasts HALF cycles. HALF is the larger of HALF_DIV and ceil(SCLK_MIN_PERIOD_PS / (2*CLK_PERIOD_PS)), which gives 5 with the defaults.
- R6: Each frame has exactly 24 falling edges of `sclk`. `done` is high for exactly one cycle: the first cycle in which `sclk` shows its 24th low.
- R7: `req_ready` is low from the cycle after acceptance until the `done` cycle, and high from the `done` cycle on. A request accepted during the final low phase sends `sclk` high and `sync` high in the next cycle.
- R8: When `req_ready` is low, `req_valid`, `req_code` and `req_mode` have no effect. The frame in flight and its timing do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_code | input | 16 | DAC output code |
| req_mode | input | 2 | Power mode bits |
| sclk | output | 1 | Serial clock, idles high |
| sync | output | 1 | Frame select; held high before a frame, low during it |
| din | output | 1 | Serial data, sampled by the receiver on `sclk` falling edges |
| done | output | 1 | One-cycle pulse on the 24th falling edge |

## Verification
The bench feeds frames whose bit patterns expose ordering errors: all ones, all zeros, alternating bits, and patterns set only at the ends. A swapped field or a frame sent LSB first then shows up as a wrong captured word. It offers a request in the very cycle that `done` is high. A design that kept `req_ready` low through the tail, or that dropped the cut-short low phase, would drift from the cycle-exact model. It also pulses `req_valid` with different data partway through a frame. A design that sampled inputs while busy would corrupt the frame or restart it. The SYNC-high run and every `sclk` low phase are measured, so an off-by-one in either count fails the check.

// File: rtl/dac_frame_writer.sv
module dac_frame_writer #(
  parameter int CLK_PERIOD_PS      = 4000,
  parameter int SYNC_MIN_PS        = 33000,
  parameter int SCLK_MIN_PERIOD_PS = 33334,
  parameter int HALF_DIV           = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_code,
  input  logic [1:0]  req_mode,
  output logic        sclk,
  output logic        sync,
  output logic        din,
  output logic        done
);

  localparam int FRAME_W  = 24;
  localparam int PAD_W    = 6;
  localparam int SYNC_RAW = (SYNC_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SYNC_CYC = (SYNC_RAW < 1) ? 1 : SYNC_RAW;
  localparam int MIN_HALF = (SCLK_MIN_PERIOD_PS + 2*CLK_PERIOD_PS - 1) / (2*CLK_PERIOD_PS);
  localparam int HALF_A   = (HALF_DIV > MIN_HALF) ? HALF_DIV : MIN_HALF;
  localparam int HALF     = (HALF_A < 1) ? 1 : HALF_A;
  localparam int CNT_MAX  = (SYNC_CYC > HALF) ? SYNC_CYC : HALF;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam int BW       = $clog2(FRAME_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_SHIFT, ST_TAIL} state_t;

  state_t             st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] shreg;

  assign req_ready = (st == ST_IDLE) || (st == ST_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      sclk  <= 1'b1;
      sync  <= 1'b0;
      din   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE, ST_TAIL: begin
          if (req_valid) begin
            st    <= ST_ARM;
            sync  <= 1'b1;
            sclk  <= 1'b1;
            din   <= 1'b0;
            shreg <= {{PAD_W{1'b0}}, req_mode, req_code};
            cnt   <= CW'(SYNC_CYC - 1);
          end else if (st == ST_TAIL) begin
            if (cnt == '0) begin
              sclk <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_ARM: begin
          if (cnt == '0) begin
            st    <= ST_SHIFT;
            sync  <= 1'b0;
            din   <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            bitn  <= '0;
            cnt   <= CW'(HALF - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (sclk) begin
            sclk <= 1'b0;
            cnt  <= CW'(HALF - 1);
            if (bitn == BW'(FRAME_W - 1)) begin
              done <= 1'b1;
              st   <= ST_TAIL;
            end
          end else begin
            sclk  <= 1'b1;
            din   <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            bitn  <= bitn + 1'b1;
            cnt   <= CW'(HALF - 1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic        sclk_d, sync_d;
  logic [4:0]  falls;
  logic [15:0] hi_run, sc_hi, sc_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      sync_d <= 1'b0;
      falls  <= '0;
      hi_run <= '0;
      sc_hi  <= '0;
      sc_lo  <= '0;
    end else begin
      sclk_d <= sclk;
      sync_d <= sync;
      if (sync)                falls <= '0;
      else if (sclk_d && !sclk) falls <= falls + 1'b1;
      hi_run <= sync ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      sc_hi  <= sclk ? ((sc_hi == 16'hFFFF) ? sc_hi : sc_hi + 1'b1) : '0;
      sc_lo  <= !sclk ? ((sc_lo == 16'hFFFF) ? sc_lo : sc_lo + 1'b1) : '0;
    end
  end

  AST_SYNC_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_d && !sync) |-> (hi_run >= 16'(SYNC_CYC))); // R3
  AST_DIN_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_d && !sclk) |-> $stable(din)); // R2
  AST_SYNC_RISE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_d && sync) |-> (falls == 5'd0 || falls == 5'(FRAME_W))); // R4
  AST_DONE_AT_LAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk_d && !sclk && !sync && falls == 5'(FRAME_W - 1))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !req_ready); // R7
  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_d && !sclk) |-> (sc_hi >= 16'(HALF))); // R5
  AST_SCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_d && sclk && !sync) |-> (sc_lo >= 16'(HALF))); // R5

endmodule

// File: tb/dac_frame_writer_tb.sv
module dac_frame_writer_tb_top;
  localparam int SYNC_N = 9;
  localparam int HALF_N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_code = '0;
  logic [1:0]  req_mode = '0;
  logic req_ready, sclk, sync, din, done;

  always #2 clk = ~clk;

  dac_frame_writer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_mode(req_mode), .sclk(sclk), .sync(sync),
    .din(din), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // reference model: {sync, sclk, din, ready, done}
  logic [4:0]  cur = 5'b01010;
  logic [4:0]  q[$];
  logic [23:0] exp_frames[$];

  task automatic build(input logic [23:0] f);
    q.delete();
    exp_frames.push_back(f);
    for (int i = 0; i < SYNC_N; i++) q.push_back(5'b11000);
    for (int b = 23; b >= 0; b--) begin
      for (int i = 0; i < HALF_N; i++) q.push_back({2'b01, f[b], 2'b00});
      if (b > 0) begin
        for (int i = 0; i < HALF_N; i++) q.push_back({2'b00, f[b], 2'b00});
      end else begin
        q.push_back({2'b00, f[b], 2'b11});
        for (int i = 1; i < HALF_N; i++) q.push_back({2'b00, f[b], 2'b10});
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur = 5'b01010;
      q.delete();
    end else begin
      if (req_valid && cur[1]) build({6'b0, req_mode, req_code});
      if (q.size() > 0) cur = q.pop_front();
      else cur = {2'b01, cur[2], 2'b10};
    end
  end

  // per-cycle comparison and frame capture
  logic        prev_sclk = 1'b1, prev_sync = 1'b0;
  logic [23:0] cap = '0;
  int          nfall = 0, sync_run = 0, low_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sync == cur[4], "R3/R4 sync vs model", sync, cur[4]);
      chk(sclk == cur[3], "R5 sclk vs model", sclk, cur[3]);
      chk(din == cur[2], "R2 din vs model", din, cur[2]);
      chk(req_ready == cur[1], "R7/R8 req_ready vs model", req_ready, cur[1]);
      chk(done == cur[0], "R6 done vs model", done, cur[0]);
      if (sync) begin
        sync_run++;
        cap = '0;
        nfall = 0;
      end else begin
        if (prev_sync) chk(sync_run == SYNC_N, "R3 sync high length", sync_run, SYNC_N);
        sync_run = 0;
        if (prev_sclk && !sclk) begin
          cap = {cap[22:0], din};
          nfall++;
        end
        if (!prev_sclk && sclk) chk(low_run == HALF_N, "R5 sclk low length", low_run, HALF_N);
      end
      low_run = sclk ? 0 : low_run + 1;
      if (done) begin
        chk(nfall == 24, "R6 falling edge count", nfall, 24);
        if (exp_frames.size() > 0) begin
          logic [23:0] e;
          e = exp_frames.pop_front();
          chk(cap == e, "R1 captured frame", cap, e);
        end else chk(0, "R1 frame without request", cap, 0);
      end
      prev_sclk = sclk;
      prev_sync = sync;
    end
  end

  task automatic send(input logic [15:0] c, input logic [1:0] m, input bit keep);
    @(negedge clk);
    req_valid = 1'b1; req_code = c; req_mode = m;
    while (!req_ready) @(negedge clk);
    if (!keep) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sync == 1'b0 && sclk == 1'b1 && din == 1'b0 && req_ready == 1'b1 && done == 1'b0,
        "R4 reset state", {sync, sclk, din, req_ready, done}, 5'b01010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sync == 1'b0 && req_ready == 1'b1, "R4 idle sync low", sync, 0);

    send(16'hA5C3, 2'd2, 0);
    wait_done();
    repeat (20) @(negedge clk);
    send(16'hFFFF, 2'd3, 0);
    wait_done();
    send(16'h0000, 2'd0, 0);
    wait_done();
    repeat (3) @(negedge clk);
    // R8: busy-time request with other data is ignored
    send(16'h8001, 2'd1, 0);
    repeat (40) @(negedge clk);
    req_valid = 1'b1; req_code = 16'h1234; req_mode = 2'd3;
    repeat (30) @(negedge clk);
    req_valid = 1'b0;
    chk(exp_frames.size() == 1, "R8 busy request ignored", exp_frames.size(), 1);
    wait_done();
    // R7: back-to-back accept in the done cycle
    send(16'h5555, 2'd1, 1);
    req_code = 16'hAAAA; req_mode = 2'd2;
    wait_done();
    @(negedge clk);
    req_valid = 1'b0;
    chk(sync == 1'b1, "R7 accept during tail restarts frame", sync, 1);
    wait_done();
    repeat (HALF_N + 2) @(negedge clk);
    chk(sclk == 1'b1 && sync == 1'b0, "R4 idle after frame", {sclk, sync}, 2'b10);
    chk(exp_frames.size() == 0, "R6 every frame completed", exp_frames.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule